// File: doc/BRIEF.md
# Truth Table Fitness Evaluator

This block scores a candidate combinational circuit against a stored truth table. After a start pulse it walks every one of the 2^N_IN input vectors in ascending order, drives each onto the circuit under test and onto the address of an expected-output memory, waits one cycle for settling and for the memory's registered read, and then compares all N_OUT response bits with the expected bits. It keeps a running count of bit mismatches.

When the sweep ends, the block turns the mismatch count into a functional percentage in fixed point with 8 fractional bits. If not a single bit was wrong, it adds a gate-economy score. For that score each cell descriptor gives the cell's input count and an active flag. A k-input cell is counted as k-1 two-input primitives. The economy score is the cell count times the primitive count of the widest cell, minus the primitives of the active cells. The result appears on a held fitness output, and a one-cycle done pulse marks it. An evolutionary search loop uses the block to rank candidate configurations.

Top module: `tt_fitness_eval`

## Requirements
- R1: During and right after reset, done is 0, fitness is 0 and vec_out is 0.
- R2: An accepted start sets vec_out to 0. Each vector is then held for two cycles and the sweep climbs by one up to 2^N_IN-1. exp_addr always equals vec_out.
- R3: In the second cycle of each vector, cut_resp is compared with exp_data. The memory returns exp_data one cycle after exp_addr.
- R4: Mismatches are counted bit by bit over all N_OUT outputs of all vectors, giving a total E between 0 and N_OUT*2^N_IN.
- R5: The functional score is 25600 - floor(25600*E/(N_OUT*2^N_IN)). This is 100 percent times 256, so 25600 means fully correct and 0 means every bit is wrong.
- R6: If E is nonzero, fitness equals the functional score. If E is 0, fitness is 25600 + 256*S, where S is the economy score.
- R7: A cell whose fanin field holds k>=1 counts as k-1 primitives. A fanin of 0 counts as 0. Each fanin field is FW bits wide, and cell i occupies bits [i*FW +: FW] of cell_fanin.
- R8: S = N_CELLS * (the largest primitive count among all cells, active or not) - (the sum of the primitive counts of the cells whose cell_active bit is 1).
- R9: done rises exactly 2*2^N_IN+1 cycles after the edge that accepts start and stays high for one cycle. fitness changes only in the cycle done is high.
- R10: A start pulse during a sweep is ignored. The sweep and the done timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a scoring run when idle |
| done | output | 1 | One-cycle pulse: fitness updated |
| vec_out | output | N_IN | Input vector driven to the circuit under test |
| cut_resp | input | N_OUT | Circuit-under-test response |
| exp_addr | output | N_IN | Expected-output memory address |
| exp_data | input | N_OUT | Expected-output memory data, one-cycle read latency |
| cell_fanin | input | N_CELLS*FW | Packed per-cell input counts |
| cell_active | input | N_CELLS | Per-cell connected flags |
| fitness | output | FIT_W | Fitness in fixed point, 8 fractional bits |

## Verification
The bench uses the defaults: 4 inputs, 3 outputs, 8 cells and a maximum fanin of 8. A sweep therefore has 16 vectors and 48 output bits. This puts the full range of the mismatch count within reach: zero, a single bit, every bit wrong, and random masks in between. The rounding of the division can be checked at each of these points. Eight cells with fanin values from 0 to 8 cover the widest cell being inactive, fanin 0 and fanin 1, and the worked case where 8 cells with a widest cell of 5 inputs give an economy score of 19.

// File: rtl/tt_fitness_eval.sv
module tt_fitness_eval #(
  parameter int N_IN      = 4,
  parameter int N_OUT     = 3,
  parameter int N_CELLS   = 8,
  parameter int MAX_FANIN = 8,
  parameter int FRAC      = 8,
  parameter int FW        = $clog2(MAX_FANIN + 1),
  parameter int FIT_W     = $clog2((100 << FRAC) + ((N_CELLS * (MAX_FANIN - 1)) << FRAC) + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic                    done,
  output logic [N_IN-1:0]         vec_out,
  input  logic [N_OUT-1:0]        cut_resp,
  output logic [N_IN-1:0]         exp_addr,
  input  logic [N_OUT-1:0]        exp_data,
  input  logic [N_CELLS*FW-1:0]   cell_fanin,
  input  logic [N_CELLS-1:0]      cell_active,
  output logic [FIT_W-1:0]        fitness
);
  localparam int P      = 1 << N_IN;
  localparam int MP     = N_OUT * P;
  localparam int SCALE  = 100 << FRAC;
  localparam int ERR_W  = $clog2(MP + 1);
  localparam int PROD_W = $clog2(SCALE + 1) + ERR_W;
  localparam int OPT_W  = $clog2(N_CELLS * MAX_FANIN + 1);

  typedef enum logic [1:0] {S_IDLE, S_APPLY, S_CHECK, S_SCORE} state_t;
  state_t state;

  logic [ERR_W-1:0]  err;
  logic              busy;
  logic [PROD_W-1:0] prod, penalty;
  logic [FIT_W-1:0]  func_q;
  logic [FW-1:0]     maxp;
  logic [OPT_W-1:0]  usedp, opt;

  assign busy     = (state != S_IDLE);
  assign exp_addr = vec_out;
  assign prod     = PROD_W'(SCALE) * PROD_W'(err);
  assign penalty  = prod / PROD_W'(MP);
  assign func_q   = FIT_W'(SCALE) - FIT_W'(penalty);

  always_comb begin
    logic [FW-1:0] pr;
    maxp  = '0;
    usedp = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      pr = (cell_fanin[i*FW +: FW] == '0) ? '0 : cell_fanin[i*FW +: FW] - 1'b1;
      if (pr > maxp) maxp = pr;
      if (cell_active[i]) usedp = usedp + OPT_W'(pr);
    end
  end

  assign opt = OPT_W'(OPT_W'(N_CELLS) * OPT_W'(maxp)) - usedp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      vec_out <= '0;
      err     <= '0;
      done    <= 1'b0;
      fitness <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_APPLY;
          vec_out <= '0;
          err     <= '0;
        end
        S_APPLY: state <= S_CHECK;
        S_CHECK: begin
          err <= err + ERR_W'($countones(cut_resp ^ exp_data));
          if (&vec_out) state <= S_SCORE;
          else begin
            vec_out <= vec_out + 1'b1;
            state   <= S_APPLY;
          end
        end
        S_SCORE: begin
          fitness <= func_q + ((err == '0) ? (FIT_W'(opt) << FRAC) : '0);
          done    <= 1'b1;
          state   <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tt_fitness_eval_chk.sv
module tt_fitness_eval_chk #(
  parameter int N_IN  = 4,
  parameter int FIT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [N_IN-1:0]  vec_out,
  input logic [FIT_W-1:0] fitness
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_fit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(fitness));
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
  p_vec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_out != $past(vec_out)) |-> ((vec_out == N_IN'($past(vec_out) + 1'b1)) || (vec_out == '0)));
endmodule

bind tt_fitness_eval tt_fitness_eval_chk #(.N_IN(N_IN), .FIT_W(FIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .vec_out(vec_out), .fitness(fitness)
);

// File: tb/tb_tt_fitness_eval.sv
module tb_tt_fitness_eval;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 4, N_OUT = 3, N_CELLS = 8, MAX_FANIN = 8;
  localparam int FW = $clog2(MAX_FANIN + 1);
  localparam int FIT_W = $clog2(25600 + ((N_CELLS * (MAX_FANIN - 1)) << 8) + 1);
  localparam int P = 1 << N_IN;

  logic clk = 0, rst_n = 0, start = 0;
  logic done;
  logic [N_IN-1:0] vec_out, exp_addr;
  logic [N_OUT-1:0] cut_resp, exp_data;
  logic [N_CELLS*FW-1:0] cell_fanin = '0;
  logic [N_CELLS-1:0] cell_active = '0;
  logic [FIT_W-1:0] fitness;

  logic [N_OUT-1:0] tt [P];
  logic [N_OUT-1:0] emask [P];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_fitness_eval #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CELLS(N_CELLS), .MAX_FANIN(MAX_FANIN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .vec_out(vec_out),
    .cut_resp(cut_resp), .exp_addr(exp_addr), .exp_data(exp_data),
    .cell_fanin(cell_fanin), .cell_active(cell_active), .fitness(fitness));

  assign cut_resp = tt[vec_out] ^ emask[vec_out];
  always_ff @(posedge clk) exp_data <= tt[exp_addr];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_fit();
    int e = 0, mx = 0, used = 0, pr;
    for (int v = 0; v < P; v++) e += $countones(emask[v]);
    if (e != 0) return 25600 - (25600 * e) / (N_OUT * P);
    for (int i = 0; i < N_CELLS; i++) begin
      pr = int'(cell_fanin[i*FW +: FW]);
      pr = (pr == 0) ? 0 : pr - 1;
      if (pr > mx) mx = pr;
      if (cell_active[i]) used += pr;
    end
    return 25600 + ((N_CELLS * mx - used) << 8);
  endfunction

  task automatic run(input string req, input bit mid_start);
    int bad_vec = 0, bad_done = 0, bad_addr = 0;
    int expv;
    int prev_fit;
    expv = exp_fit();
    prev_fit = int'(fitness);
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
    for (int c = 1; c <= 2*P + 2; c++) begin
      @(negedge clk);
      if (mid_start) start = (c == 5);
      if (c <= 2*P && int'(vec_out) != (c - 1) / 2) bad_vec++;
      if (exp_addr != vec_out) bad_addr++;
      if (done != (c == 2*P + 2)) bad_done++;
      if (c < 2*P + 2 && int'(fitness) != prev_fit) bad_done++;
    end
    start = 0;
    chk(bad_vec == 0, "R2 vector order", bad_vec, 0);
    chk(bad_addr == 0, "R2 exp_addr follows vec_out", bad_addr, 0);
    chk(bad_done == 0, mid_start ? "R10 mid-run start ignored" : "R9 done timing", bad_done, 0);
    chk(int'(fitness) == expv, req, int'(fitness), expv);
    @(negedge clk);
    chk(!done && int'(fitness) == expv, "R9 pulse ends, fitness held", int'(fitness), expv);
  endtask

  task automatic set_cell(input int i, input int k, input bit a);
    cell_fanin[i*FW +: FW] = FW'(k);
    cell_active[i] = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int v = 0; v < P; v++) begin tt[v] = N_OUT'($urandom); emask[v] = '0; end
    repeat (3) @(negedge clk);
    chk(done == 0 && fitness == 0 && vec_out == 0, "R1 reset state", int'(fitness), 0);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && fitness == 0 && vec_out == 0, "R1 after reset", int'(vec_out), 0);

    // Worked example: widest gate 5 inputs, active primitives 1+2+3+4+3=13 -> 19
    set_cell(0, 2, 1); set_cell(1, 3, 1); set_cell(2, 2, 0); set_cell(3, 4, 1);
    set_cell(4, 3, 0); set_cell(5, 5, 1); set_cell(6, 4, 1); set_cell(7, 1, 0);
    run("R6 R8 worked example", 0);
    chk(int'(fitness) == 25600 + 19*256, "R8 economy score 19", int'(fitness), 25600 + 19*256);

    // Fanin 0 and 1 count as 0; widest inactive still sets the max
    set_cell(0, 0, 1); set_cell(1, 1, 1); set_cell(2, 8, 0); set_cell(3, 2, 1);
    set_cell(4, 0, 0); set_cell(5, 1, 0); set_cell(6, 3, 1); set_cell(7, 0, 1);
    run("R7 fanin 0/1 and inactive widest", 0);

    // Single bit error: functional score only
    emask[7] = 3'b010;
    run("R5 single mismatch", 0);
    chk(int'(fitness) == 25600 - 533, "R6 no economy bonus when wrong", int'(fitness), 25067);

    // Every bit wrong
    for (int v = 0; v < P; v++) emask[v] = '1;
    run("R4 all bits wrong", 0);
    chk(fitness == 0, "R5 zero score", int'(fitness), 0);

    // Errors on first and last vectors only (R3 sampling at sweep ends)
    for (int v = 0; v < P; v++) emask[v] = '0;
    emask[0] = 3'b001; emask[P-1] = 3'b100;
    run("R3 first and last vector compared", 0);

    // Start during a sweep
    for (int v = 0; v < P; v++) emask[v] = '0;
    run("R10 fitness unaffected by mid-run start", 1);

    // Random mixes
    for (int t = 0; t < 6; t++) begin
      for (int v = 0; v < P; v++) begin
        tt[v] = N_OUT'($urandom);
        emask[v] = (t % 2 == 0) ? N_OUT'($urandom & $urandom) : '0;
      end
      for (int i = 0; i < N_CELLS; i++) set_cell(i, $urandom_range(0, MAX_FANIN), 1'($urandom));
      run("R4 R5 R6 random", 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule